// File: doc/BRIEF.md
# UART interrupt status and mask controller

This block gathers the condition and event signals of a UART and turns them into one interrupt line. Live FIFO fill levels and the two activity flags form a raw status word that is recomputed every cycle. Selected status conditions, together with one-cycle event pulses from the receiver and transmitter (overflows, framing and parity errors, receive timeout, modem change), are latched into a sticky interrupt word. Software acknowledges causes by writing ones to the sticky word.

A mask decides which sticky causes reach the interrupt pin. Software never writes the mask directly. One register address ORs ones into it and another clears the bits written as one. Two threshold registers define the receive and transmit trigger levels used in the status word. A simple single-cycle register port with a combinational read path gives access to all of this. The FIFOs, the serial engine and the modem logic sit outside the block and only feed it counts and pulses.

Top module: `uirq_ctrl`

## Requirements
- R1: The status word read at address 4 carries: bit 0 rx_count >= rx threshold, bit 1 rx_count == 0, bit 2 rx_count == DEPTH, bit 3 tx_count == 0, bit 4 tx_count == DEPTH, bit 10 rx_active, bit 11 tx_active, bit 13 tx_count >= tx threshold; all other bits read 0. It follows the inputs in the same cycle.
- R2: The rx threshold is at address 5 and the tx threshold at address 6. Both are CNT_W bits wide, writable and readable. The trigger comparison is greater-than-or-equal, so a count equal to the threshold triggers.
- R3: At every clock edge, each of status bits 0 to 4 that is high sets the same bit of the sticky word (address 3).
- R4: The tx-trigger condition sets sticky bit 10; the sticky word has no bit 13 (it is 13 bits wide, bits 0..12).
- R5: Event pulses set sticky bits at the next edge: rx overflow bit 5, framing error bit 6, parity error bit 7, receive timeout bit 8, modem change bit 9, tx overflow bit 12.
- R6: A write to address 3 clears the sticky bits written as one and leaves the others unchanged.
- R7: A sticky bit that hardware sets in the same cycle as a write-one-to-clear of that bit stays set.
- R8: A write to address 0 ORs the data into the 13-bit mask, and a write to address 1 clears the mask bits written as one. A write to address 2 has no effect. The mask reads at address 2; data bits 13 and up are not stored.
- R9: irq is high exactly when some bit is set in both mask and sticky word. It follows a mask or sticky change after the same clock edge that makes it.
- R10: After reset the mask and sticky word are 0, both thresholds read 32 and irq is low.
- R11: Addresses 0, 1 and 7 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_count | input | CNT_W | Receive FIFO fill level |
| tx_count | input | CNT_W | Transmit FIFO fill level |
| rx_active | input | 1 | Receiver busy with a character |
| tx_active | input | 1 | Transmitter busy with a character |
| ev_rx_ovr | input | 1 | Receive overflow pulse |
| ev_frame | input | 1 | Framing error pulse |
| ev_parity | input | 1 | Parity error pulse |
| ev_timeout | input | 1 | Receive timeout pulse |
| ev_modem | input | 1 | Modem status change pulse |
| ev_tx_ovr | input | 1 | Transmit overflow pulse |
| reg_addr | input | 4 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The status word and all read data are combinational, so the bench reads them 1 ns after it drives the address or the inputs, before any clock edge. Sticky bits, mask bits, thresholds and irq change at the first rising edge after the stimulus. The bench therefore drives at a falling edge and samples at the next falling edge, which gives exactly one rising edge in between. When a test needs a status condition to exist without being latched, the bench drives and reads it and then removes it inside the same half period.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ADDR_W = 4;
  localparam int ST_W   = 14;  // raw status word width
  localparam int SK_W   = 13;  // sticky / mask width

  // raw status bit positions
  localparam int ST_RXTRIG  = 0;
  localparam int ST_RXEMPTY = 1;
  localparam int ST_RXFULL  = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_TXFULL  = 4;
  localparam int ST_RXACT   = 10;
  localparam int ST_TXACT   = 11;
  localparam int ST_TXTRIG  = 13;

  // sticky bit positions
  localparam int SK_RXEMPTY = 1;
  localparam int SK_RXOVR   = 5;
  localparam int SK_FRAME   = 6;
  localparam int SK_PARITY  = 7;
  localparam int SK_TIMEOUT = 8;
  localparam int SK_MODEM   = 9;
  localparam int SK_TXTRIG  = 10;
  localparam int SK_TXOVR   = 12;

  typedef enum logic [ADDR_W-1:0] {
    A_MSET   = 4'd0,
    A_MCLR   = 4'd1,
    A_MASK   = 4'd2,
    A_STICKY = 4'd3,
    A_STATUS = 4'd4,
    A_RXTHR  = 4'd5,
    A_TXTHR  = 4'd6
  } reg_addr_e;
endpackage

// File: rtl/uirq_status.sv
module uirq_status
  import uirq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_thr,
  input  logic [CNT_W-1:0] tx_thr,
  input  logic             rx_act,
  input  logic             tx_act,
  output logic [ST_W-1:0]  status
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  // R1: pack the live conditions into the raw status word
  function automatic logic [ST_W-1:0] pack_status(
    input logic [CNT_W-1:0] rc, tc, rt, tt,
    input logic ra, ta);
    logic [ST_W-1:0] s;
    s             = '0;
    s[ST_RXTRIG]  = (rc >= rt);
    s[ST_RXEMPTY] = (rc == '0);
    s[ST_RXFULL]  = (rc == FULL_LVL);
    s[ST_TXEMPTY] = (tc == '0);
    s[ST_TXFULL]  = (tc == FULL_LVL);
    s[ST_RXACT]   = ra;
    s[ST_TXACT]   = ta;
    s[ST_TXTRIG]  = (tc >= tt);
    return s;
  endfunction

  assign status = pack_status(rx_cnt, tx_cnt, rx_thr, tx_thr, rx_act, tx_act);

  // R1: empty and full can never be reported together for one FIFO
  always_comb begin
    rx_excl_chk: assert (!(status[ST_RXEMPTY] && status[ST_RXFULL]) || DEPTH == 0);
  end
endmodule

// File: rtl/uirq_sticky.sv
module uirq_sticky #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  // R6/R7: hardware set has priority over software clear
  function automatic logic [W-1:0] next_sticky(
    input logic [W-1:0] cur, set, clr);
    return (cur & ~clr) | set;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_sticky(q, set_vec, clr_vec);
  end

  // R7
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((q & $past(set_vec)) == $past(set_vec)));
  // R6
  sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((q & $past(clr_vec & ~set_vec)) == '0));
  // R6
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> (($past(q) & ~q) == '0));
endmodule

// File: rtl/uirq_mask.sv
module uirq_mask #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wbits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= q | wbits;
    else if (clr_en) q <= q & ~wbits;
  end

  // R8
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(wbits)) == $past(wbits)));
  // R8
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(wbits)) == '0));
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(q));
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int CNT_W    = $clog2(DEPTH + 1),
  parameter int DATA_W   = 32,
  parameter int TRIG_RST = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              rx_active,
  input  logic              tx_active,
  input  logic              ev_rx_ovr,
  input  logic              ev_frame,
  input  logic              ev_parity,
  input  logic              ev_timeout,
  input  logic              ev_modem,
  input  logic              ev_tx_ovr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam logic [CNT_W-1:0] THR_RST = CNT_W'(TRIG_RST);

  // write decode, brought out as named events
  logic wr_mset, wr_mclr, wr_sticky, wr_rxthr, wr_txthr;
  assign wr_mset   = reg_wen && (reg_addr == A_MSET);
  assign wr_mclr   = reg_wen && (reg_addr == A_MCLR);
  assign wr_sticky = reg_wen && (reg_addr == A_STICKY);
  assign wr_rxthr  = reg_wen && (reg_addr == A_RXTHR);
  assign wr_txthr  = reg_wen && (reg_addr == A_TXTHR);

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^reg_wdata[DATA_W-1:SK_W];

  // R2: trigger thresholds
  logic [CNT_W-1:0] rx_thr_q, tx_thr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr_q <= THR_RST;
      tx_thr_q <= THR_RST;
    end else begin
      if (wr_rxthr) rx_thr_q <= reg_wdata[CNT_W-1:0];
      if (wr_txthr) tx_thr_q <= reg_wdata[CNT_W-1:0];
    end
  end

  logic [ST_W-1:0] status;
  uirq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
    .rx_cnt(rx_count), .tx_cnt(tx_count),
    .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
    .rx_act(rx_active), .tx_act(tx_active),
    .status(status)
  );

  // R3/R4/R5: hardware set vector for the sticky word
  function automatic logic [SK_W-1:0] map_set(
    input logic [ST_W-1:0] st,
    input logic rxo, fr, par, tmo, mdm, txo);
    logic [SK_W-1:0] v;
    v             = '0;
    v[4:0]        = st[4:0];
    v[SK_TXTRIG]  = st[ST_TXTRIG];
    v[SK_RXOVR]   = rxo;
    v[SK_FRAME]   = fr;
    v[SK_PARITY]  = par;
    v[SK_TIMEOUT] = tmo;
    v[SK_MODEM]   = mdm;
    v[SK_TXOVR]   = txo;
    return v;
  endfunction

  logic [SK_W-1:0] hw_set, sw_clr, sticky_q, mask_q;
  assign hw_set = map_set(status, ev_rx_ovr, ev_frame, ev_parity,
                          ev_timeout, ev_modem, ev_tx_ovr);
  assign sw_clr = wr_sticky ? reg_wdata[SK_W-1:0] : '0;

  uirq_sticky #(.W(SK_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .set_vec(hw_set), .clr_vec(sw_clr), .q(sticky_q)
  );

  uirq_mask #(.W(SK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(wr_mset), .clr_en(wr_mclr),
    .wbits(reg_wdata[SK_W-1:0]), .q(mask_q)
  );

  // R9
  assign irq = |(mask_q & sticky_q);

  // R1/R2/R8/R11: read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK:   reg_rdata = DATA_W'(mask_q);
      A_STICKY: reg_rdata = DATA_W'(sticky_q);
      A_STATUS: reg_rdata = DATA_W'(status);
      A_RXTHR:  reg_rdata = DATA_W'(rx_thr_q);
      A_TXTHR:  reg_rdata = DATA_W'(tx_thr_q);
      default:  reg_rdata = '0;
    endcase
  end

  // R9
  irq_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sticky_q != '0));
  // R3
  rxempty_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0) |=> sticky_q[SK_RXEMPTY]);
  // R4
  txtrig_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count >= tx_thr_q) |=> sticky_q[SK_TXTRIG]);
  // R5
  frame_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |=> sticky_q[SK_FRAME]);
endmodule

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] rx_count = 7'd5, tx_count = 7'd5;
  logic rx_active = 0, tx_active = 0;
  logic ev_rx_ovr = 0, ev_frame = 0, ev_parity = 0, ev_timeout = 0, ev_modem = 0, ev_tx_ovr = 0;
  logic [3:0] reg_addr = 4'd0;
  logic reg_wen = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uirq_ctrl u_uirq_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
    .rx_active(rx_active), .tx_active(tx_active),
    .ev_rx_ovr(ev_rx_ovr), .ev_frame(ev_frame), .ev_parity(ev_parity),
    .ev_timeout(ev_timeout), .ev_modem(ev_modem), .ev_tx_ovr(ev_tx_ovr),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // independent model of the status word
  function automatic logic [31:0] model_status(int rxc, int txc, int rxt, int txt, bit ra, bit ta);
    logic [31:0] r = 0;
    if (rxc >= rxt)   r = r | 32'h0001;
    if (rxc == 0)     r = r | 32'h0002;
    if (rxc == DEPTH) r = r | 32'h0004;
    if (txc == 0)     r = r | 32'h0008;
    if (txc == DEPTH) r = r | 32'h0010;
    if (ra)           r = r | 32'h0400;
    if (ta)           r = r | 32'h0800;
    if (txc >= txt)   r = r | 32'h2000;
    return r;
  endfunction

  task automatic quiet_clear();
    rx_count = 5; tx_count = 5; rx_active = 0; tx_active = 0;
    wr(4'd3, 32'h1FFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd2, v); chk("R10 mask", v, 0);
    rd(4'd3, v); chk("R10 sticky", v, 0);
    rd(4'd5, v); chk("R10 rx thr", v, 32);
    rd(4'd6, v); chk("R10 tx thr", v, 32);
    chk("R10 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    rx_count = 0; tx_count = 64; rx_active = 1; tx_active = 0;
    rd(4'd4, v); chk("R1 pattern A", v, model_status(0, 64, 32, 32, 1, 0));
    rx_count = 64; tx_count = 0; rx_active = 0; tx_active = 1;
    rd(4'd4, v); chk("R1 pattern B", v, model_status(64, 0, 32, 32, 0, 1));
    rx_count = 5; tx_count = 5; tx_active = 0;
    rd(4'd4, v); chk("R1 quiet", v, 0);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    rx_count = 4; tx_count = 5;
    wr(4'd5, 32'd5);
    wr(4'd6, 32'd6);
    rd(4'd5, v); chk("R2 rx thr read", v, 5);
    rd(4'd6, v); chk("R2 tx thr read", v, 6);
    rx_count = 5; tx_count = 6;
    rd(4'd4, v); chk("R2 equal triggers", v, model_status(5, 6, 5, 6, 0, 0));
    rx_count = 4; tx_count = 5;
    rd(4'd4, v); chk("R2 below no trigger", v, 0);
    wr(4'd5, 32'd32);
    wr(4'd6, 32'd32);
    rx_count = 5;
  endtask

  task automatic t_capture();
    logic [31:0] v;
    quiet_clear();
    rd(4'd3, v); chk("R6 clear all", v, 0);
    rx_count = 0;
    @(negedge clk);
    rx_count = 5;
    rd(4'd3, v); chk("R3 rx empty latched", v, 32'h002);
    quiet_clear();
    tx_count = 64;
    @(negedge clk);
    tx_count = 5;
    rd(4'd3, v); chk("R3/R4 tx full latched with trigger at bit 10", v, 32'h410);
  endtask

  task automatic t_txtrig();
    logic [31:0] v;
    quiet_clear();
    wr(4'd6, 32'd8);
    tx_count = 10;
    @(negedge clk);
    tx_count = 5;
    rd(4'd3, v); chk("R4 tx trigger bit 10 not 13", v, 32'h400);
    wr(4'd6, 32'd32);
  endtask

  task automatic t_events();
    logic [31:0] v;
    quiet_clear();
    ev_rx_ovr = 1; ev_frame = 1; ev_parity = 1; ev_timeout = 1; ev_modem = 1; ev_tx_ovr = 1;
    @(negedge clk);
    ev_rx_ovr = 0; ev_frame = 0; ev_parity = 0; ev_timeout = 0; ev_modem = 0; ev_tx_ovr = 0;
    rd(4'd3, v); chk("R5 event bits", v, 32'h13E0);
    wr(4'd3, 32'h0020);
    rd(4'd3, v); chk("R6 partial clear", v, 32'h13C0);
    wr(4'd3, 32'h1FFF);
    rd(4'd3, v); chk("R6 full clear", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    quiet_clear();
    ev_frame = 1; ev_parity = 1;
    @(negedge clk);
    ev_frame = 0; ev_parity = 0;
    ev_frame = 1;
    wr(4'd3, 32'h00C0);
    ev_frame = 0;
    rd(4'd3, v); chk("R7 set beats clear", v, 32'h0040);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(4'd0, 32'h00F0);
    rd(4'd2, v); chk("R8 set", v, 32'h0F0);
    wr(4'd0, 32'h0300);
    rd(4'd2, v); chk("R8 or-in", v, 32'h3F0);
    wr(4'd1, 32'h0030);
    rd(4'd2, v); chk("R8 clear", v, 32'h3C0);
    wr(4'd2, 32'hFFFF);
    rd(4'd2, v); chk("R8 direct write ignored", v, 32'h3C0);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd2, v); chk("R8 width", v, 32'h1FFF);
    wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd0, 32'h03C0);
  endtask

  task automatic t_irq();
    quiet_clear();
    chk("R9 idle low", {31'b0, irq}, 0);
    ev_timeout = 1;
    @(negedge clk);
    ev_timeout = 0;
    chk("R9 masked cause raises", {31'b0, irq}, 1);
    wr(4'd3, 32'h0100);
    chk("R9 ack drops", {31'b0, irq}, 0);
    ev_rx_ovr = 1;
    @(negedge clk);
    ev_rx_ovr = 0;
    chk("R9 unmasked cause ignored", {31'b0, irq}, 0);
    wr(4'd0, 32'h0020);
    chk("R9 mask enable raises", {31'b0, irq}, 1);
    wr(4'd1, 32'h0020);
    chk("R9 mask disable drops", {31'b0, irq}, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(4'd0, v);  chk("R11 addr 0", v, 0);
    rd(4'd1, v);  chk("R11 addr 1", v, 0);
    rd(4'd7, v);  chk("R11 addr 7", v, 0);
    rd(4'd15, v); chk("R11 addr 15", v, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    @(negedge clk);
    t_status();
    t_thresh();
    t_capture();
    t_txtrig();
    t_events();
    t_collide();
    t_mask();
    t_irq();
    t_unmapped();
    finish_run();
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule